// File: doc/BRIEF.md
# Frame Write DMA Engine

This block is a single-channel DMA engine that copies one frame of 32-bit words from a local word stream into host memory. Software sets a bus address and a word count, then writes a control word. That control word carries the start request, the end-of-transfer interrupt enable and the transfer direction in a single write. When the start is accepted, the engine takes words from the local stream one at a time. Each word goes to the memory side as a write request. After each accepted beat the target address moves up by four bytes.

When the last word has been accepted, the engine gives a one-cycle completion pulse. If the interrupt was enabled, it also raises an interrupt line, which stays high until software acknowledges it. The acknowledge is a control write with the start bit clear, and it never begins a transfer. A start that would be unsafe is refused and flagged instead of run: a zero count, an unaligned address or the host-to-device direction. The memory side of this engine can only write, so the host-to-device direction cannot be carried out.

Top module: `frame_dma_engine`

## Requirements
- R1: After reset all three registers read zero, the engine is idle, and the interrupt, completion pulse, write-request valid and stream-ready outputs are low.
- R2: Register select 0 holds the bus address (all 32 bits readable). Select 1 holds the word count in bits [20:0], and bits [31:21] always read zero. Select 3 reads zero.
- R3: A control write (select 2) with bit 2 (start) set and bit 3 (direction) set starts a transfer when the engine is idle, the count is nonzero and address bits [1:0] are zero. A value of 0xF is such a write with the interrupt enabled. The transfer issues exactly count writes, at addresses base, base+4, base+8 and so on, each carrying the stream word accepted in that beat.
- R4: A word is moved only in a cycle where the engine is busy, the stream is valid and memory is ready. While memory is not ready, the request address holds. While idle, neither write-request valid nor stream ready is asserted.
- R5: The completion output is high for exactly one cycle, in the cycle right after the final word is accepted. Busy falls in that same cycle.
- R6: When the interrupt enable (control bit 1) was set by the start write, the interrupt output rises together with the completion pulse and stays high. When the enable was clear, the interrupt stays low.
- R7: A control write with bit 2 clear and bit 0 set clears the interrupt and the error flag and does not start a transfer. A value of 0x0B is such an acknowledge.
- R8: A start with a word count of zero sets the error flag (control bit 0) and moves no word.
- R9: A start with either of address bits [1:0] set sets the error flag and moves no word.
- R10: A start with direction bit 3 clear sets the error flag and moves no word.
- R11: Control reads return error in bit 0, interrupt enable in bit 1, busy in bit 2, direction in bit 3 and interrupt pending in bit 4. A start write while busy is ignored: it does not change the running transfer, its address or its remaining count, and it does not set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select for writes |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 2 | Register select for reads |
| reg_rd_data | output | 32 | Register read data (combinational) |
| src_valid | input | 1 | Local stream word valid |
| src_data | input | 32 | Local stream word |
| src_ready | output | 1 | Engine accepts stream word |
| mem_req_valid | output | 1 | Memory write request valid |
| mem_req_ready | input | 1 | Memory accepts write request |
| mem_req_addr | output | 32 | Memory write byte address |
| mem_req_data | output | 32 | Memory write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The hardest case to reach from the ports is a start write that arrives while a transfer is running. Normally a transfer finishes before software can act. To reach the case, the bench holds the stream invalid right after a start, so the engine waits with work left to do. While it waits, the bench rewrites the address register and issues a second start. It then releases the stream and checks that every beat still uses the first base address and the first count.

Sweeps over counts of one to six words cover the remaining behaviour. Each count runs under four patterns of stream gaps and memory back-pressure, so the final beat lands on both stalled and unstalled cycles. The acknowledge write is checked after every completed transfer.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
  localparam int AW = 32;
  localparam int REG_W = 32;
  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam int B_ERR  = 0;
  localparam int B_IE   = 1;
  localparam int B_GO   = 2;
  localparam int B_DIR  = 3;
  localparam int B_PEND = 4;

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + AW'(4);
  endfunction

  function automatic logic launch_legal(input logic [AW-1:0] a,
                                        input logic cnt_nonzero,
                                        input logic to_host);
    return cnt_nonzero && (a[1:0] == 2'b00) && to_host;
  endfunction
endpackage

// File: rtl/fdma_regs.sv
module fdma_regs
  import fdma_pkg::*;
#(
  parameter int CNT_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [1:0]        rd_sel,
  output logic [REG_W-1:0]  rd_data,
  input  logic              busy,
  input  logic              last_beat,
  output logic [AW-1:0]     prog_addr,
  output logic [CNT_W-1:0]  prog_count,
  output logic              launch,
  output logic              reject,
  output logic              ack,
  output logic              err_flag,
  output logic              irq
);
  localparam int PAD_W = REG_W - CNT_W;

  logic [AW-1:0]    addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q, ie_q, dir_q, pend_q;
  logic             ctrl_wr, go_req, legal;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
  assign go_req  = ctrl_wr && wr_data[B_GO] && !busy;
  assign legal   = launch_legal(addr_q, |cnt_q, wr_data[B_DIR]);
  assign launch  = go_req && legal;
  assign reject  = go_req && !legal;
  assign ack     = ctrl_wr && !wr_data[B_GO] && wr_data[B_ERR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      ie_q   <= 1'b0;
      dir_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_ADDR)  addr_q <= wr_data;
      if (wr_en && wr_sel == SEL_COUNT) cnt_q  <= wr_data[CNT_W-1:0];
      if (go_req) begin
        ie_q  <= wr_data[B_IE];
        dir_q <= wr_data[B_DIR];
        err_q <= !legal;
      end
      if (ack) begin
        err_q  <= 1'b0;
        pend_q <= 1'b0;
      end
      if (last_beat && ie_q) pend_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_ADDR:  rd_data = addr_q;
      SEL_COUNT: rd_data = {{PAD_W{1'b0}}, cnt_q};
      SEL_CTRL: begin
        rd_data[B_ERR]  = err_q;
        rd_data[B_IE]   = ie_q;
        rd_data[B_GO]   = busy;
        rd_data[B_DIR]  = dir_q;
        rd_data[B_PEND] = pend_q;
      end
      default:   rd_data = '0;
    endcase
  end

  assign prog_addr  = addr_q;
  assign prog_count = cnt_q;
  assign err_flag   = err_q;
  assign irq        = pend_q;
endmodule

// File: rtl/fdma_mover.sv
module fdma_mover
  import fdma_pkg::*;
#(
  parameter int CNT_W  = 21,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [AW-1:0]     base_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  output logic [DATA_W-1:0] mem_req_data,
  output logic              busy,
  output logic              beat,
  output logic              last_beat,
  output logic              done
);
  logic             busy_q, done_q;
  logic [AW-1:0]    addr_q;
  logic [CNT_W-1:0] left_q;

  assign beat          = busy_q && src_valid && mem_req_ready;
  assign last_beat     = beat && (left_q == CNT_W'(1));
  assign mem_req_valid = busy_q && src_valid;
  assign src_ready     = busy_q && mem_req_ready;
  assign mem_req_addr  = addr_q;
  assign mem_req_data  = src_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
    end else begin
      done_q <= last_beat;
      if (launch) begin
        busy_q <= 1'b1;
        addr_q <= base_addr;
        left_q <= word_count;
      end else if (beat) begin
        addr_q <= addr_step(addr_q);
        left_q <= left_q - CNT_W'(1);
        if (last_beat) busy_q <= 1'b0;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/frame_dma_engine.sv
module frame_dma_engine
  import fdma_pkg::*;
#(
  parameter int CNT_W  = 21,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [31:0]       reg_wr_data,
  input  logic [1:0]        reg_rd_sel,
  output logic [31:0]       reg_rd_data,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  output logic [DATA_W-1:0] mem_req_data,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  logic [AW-1:0]    prog_addr;
  logic [CNT_W-1:0] prog_count;
  logic launch_w, reject_w, ack_w, err_w, beat_w, last_w;

  fdma_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
    .rd_sel(reg_rd_sel), .rd_data(reg_rd_data),
    .busy(busy), .last_beat(last_w),
    .prog_addr(prog_addr), .prog_count(prog_count),
    .launch(launch_w), .reject(reject_w), .ack(ack_w),
    .err_flag(err_w), .irq(irq)
  );

  fdma_mover #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_mover (
    .clk(clk), .rst_n(rst_n),
    .launch(launch_w), .base_addr(prog_addr), .word_count(prog_count),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .busy(busy), .beat(beat_w), .last_beat(last_w), .done(done)
  );
endmodule

// File: rtl/fdma_checker.sv
module fdma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        irq,
  input logic        src_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        launch,
  input logic        reject,
  input logic        ack,
  input logic        err_flag,
  input logic        beat,
  input logic        last_beat
);
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !src_ready));

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_addr == $past(mem_req_addr)));

  assert_word_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !last_beat) |=> (mem_req_addr == $past(mem_req_addr) + 32'd4));

  assert_launch_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_irq_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> done);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !last_beat) |=> (!irq && !err_flag));

  assert_reject_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (!busy && err_flag));
endmodule

bind frame_dma_engine fdma_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .irq(irq),
  .src_ready(src_ready), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .launch(launch_w), .reject(reject_w), .ack(ack_w), .err_flag(err_w),
  .beat(beat_w), .last_beat(last_w)
);

// File: tb/tb_frame_dma_engine.sv
module tb_frame_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_sel = '0;
  logic [31:0] reg_wr_data = '0;
  logic [1:0]  reg_rd_sel = '0;
  logic [31:0] reg_rd_data;
  logic        src_valid = 1'b0;
  logic [31:0] src_data = '0;
  logic        src_ready;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_data;
  logic        busy, done, irq;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  frame_dma_engine dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .busy(busy), .done(done), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] val);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = val;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] val);
    reg_rd_sel = sel; #0.5;
    val = reg_rd_data;
  endtask

  function automatic logic [31:0] word_of(input logic [31:0] base, input int k);
    return {8'hA5, base[11:0], 12'(k)};
  endfunction

  // Feeds cnt words under pattern p, checking every beat and the ending.
  task automatic feed(input logic [31:0] base, input int cnt, input bit ie, input int p);
    int k = 0;
    int cyc = 0;
    while (k < cnt && cyc < 200) begin
      src_valid     = !((p == 2 || p == 3) && (cyc % 3 == 0));
      mem_req_ready = !((p == 1 || p == 3) && (cyc % 2 == 1));
      src_data      = word_of(base, k);
      #0.5;
      if (mem_req_valid !== src_valid) chk("R4 req valid follows stream", mem_req_valid, src_valid);
      if (src_valid && mem_req_ready) begin
        chk("R3 beat address", mem_req_addr, base + 32'(4 * k));
        chk("R3 beat data", mem_req_data, word_of(base, k));
        k++;
      end else if (src_valid) begin
        chk("R4 stalled address", mem_req_addr, base + 32'(4 * k));
      end
      @(posedge clk); #1;
      cyc++;
      if (k < cnt) chk("R5 busy mid transfer", {31'b0, busy}, 32'd1);
    end
    src_valid = 1'b0;
    mem_req_ready = 1'b0;
    chk("R3 word total", 32'(k), 32'(cnt));
    chk("R5 done pulse", {31'b0, done}, 32'd1);
    chk("R5 busy low", {31'b0, busy}, 32'd0);
    chk("R6 irq follows enable", {31'b0, irq}, {31'b0, ie});
    @(posedge clk); #1;
    chk("R5 done one cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic launch_run(input logic [31:0] base, input int cnt, input bit ie, input int p);
    wr(2'd0, base);
    wr(2'd1, 32'(cnt));
    wr(2'd2, ie ? 32'hF : 32'hD);
    feed(base, cnt, ie, p);
  endtask

  task automatic expect_reject(input string tag, input logic [31:0] base,
                               input int cnt, input logic [31:0] ctl);
    logic [31:0] v;
    wr(2'd0, base);
    wr(2'd1, 32'(cnt));
    wr(2'd2, ctl);
    src_valid = 1'b1; mem_req_ready = 1'b1; #0.5;
    chk({tag, " no request"}, {31'b0, mem_req_valid}, 32'd0);
    chk({tag, " not busy"}, {31'b0, busy}, 32'd0);
    rd(2'd2, v);
    chk({tag, " error bit"}, {31'b0, v[0]}, 32'd1);
    @(posedge clk); #1;
    chk({tag, " still idle"}, {31'b0, busy}, 32'd0);
    src_valid = 1'b0; mem_req_ready = 1'b0;
    wr(2'd2, 32'h0B);
    rd(2'd2, v);
    chk("R7 ack clears error", {31'b0, v[0]}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R3 watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk("R1 register zero", v, 32'd0);
    end
    chk("R1 idle outputs", {27'b0, busy, done, irq, mem_req_valid, src_ready}, 32'd0);

    // R2 register widths
    wr(2'd0, 32'hDEADBEEC);
    rd(2'd0, v); chk("R2 address readback", v, 32'hDEADBEEC);
    wr(2'd1, 32'hFFFFFFFF);
    rd(2'd1, v); chk("R2 count masked", v, 32'h001FFFFF);
    rd(2'd3, v); chk("R2 select 3 zero", v, 32'd0);

    // R3..R7 sweep over counts and flow-control patterns
    for (int c = 1; c <= 6; c++) begin
      for (int p = 0; p < 4; p++) begin
        bit ie = ((c + p) % 2) == 1;
        launch_run(32'h1000 + 32'(c * 256 + p * 16), c, ie, p);
        rd(2'd2, v);
        chk("R11 status after finish", v, {27'b0, ie, 1'b1, 1'b0, ie, 1'b0});
        wr(2'd2, 32'h0B);
        chk("R7 irq cleared", {31'b0, irq}, 32'd0);
        chk("R7 ack starts nothing", {31'b0, busy}, 32'd0);
      end
    end

    // R8, R9, R10 rejected starts
    expect_reject("R8 zero count", 32'h2000, 0, 32'hF);
    expect_reject("R9 misaligned by 2", 32'h2002, 3, 32'hF);
    expect_reject("R9 misaligned by 1", 32'h2001, 3, 32'hF);
    expect_reject("R10 host to device", 32'h2000, 3, 32'h7);

    // R11 start while busy is ignored
    wr(2'd0, 32'h3000);
    wr(2'd1, 32'd3);
    wr(2'd2, 32'hF);
    rd(2'd2, v);
    chk("R11 busy readable", {31'b0, v[2]}, 32'd1);
    wr(2'd0, 32'h4000);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'hF);
    rd(2'd2, v);
    chk("R11 no error on busy start", {31'b0, v[0]}, 32'd0);
    chk("R11 still busy", {31'b0, v[2]}, 32'd1);
    feed(32'h3000, 3, 1'b1, 0);
    wr(2'd2, 32'h0B);
    chk("R7 final ack", {31'b0, irq}, 32'd0);

    summary();
  end
endmodule